// File: doc/BRIEF.md
# Selectable-Divisor Serial CRC Engine

This block computes a cyclic redundancy check one bit per clock. It uses a single divider shift register whose length follows the chosen generator polynomial. A start-of-frame strobe clears the register and captures two settings for the frame: which of four fixed generators to use, and the direction. In the send direction, data bits are divided as they arrive. After the marked last bit, the register contents are streamed out most-significant bit first, as the check field to append. The transmitted frame, data shifted up by the check width plus this field, then divides exactly by the generator.

In the receive direction the same register divides the whole incoming frame, check field included. One cycle after the last bit the block pulses a completion strobe. At the same time it shows an error flag that is set when the final remainder is not zero. The flag stays until the next frame starts.

Top module: `crc_serial_unit`

## Requirements
- R1: While reset is active and after it is released, `ready_o`, `fcs_valid_o`, `fcs_bit_o`, `done_o` and `err_o` are all 0, and they stay so until a start-of-frame.
- R2: A `sof_i` cycle clears the divider to zero and latches `poly_sel_i` and `dir_i` (0 = send, 1 = receive). `ready_o` is 1 in the next cycle. Changes on `poly_sel_i` or `dir_i` later in the frame have no effect on the result.
- R3: A bit is taken into the divider only in a cycle where `ready_o` and `bit_valid_i` are both 1. In cycles with `bit_valid_i` low, `bit_i` and `last_i` are ignored.
- R4: In send mode, in the cycle after the bit marked by `last_i` is taken, `fcs_valid_o` rises. It stays high for exactly w cycles, where w is the generator degree. `fcs_bit_o` carries the remainder of D·x^w divided by P, most-significant bit first.
- R5: While `fcs_valid_o` is high, `ready_o` is 0. Any `bit_valid_i`, `bit_i` or `last_i` activity in those cycles does not alter the emitted bits.
- R6: In receive mode, `done_o` is high for exactly one cycle, the cycle after the last bit is taken. From that cycle `err_o` is 1 if and only if the received frame leaves a nonzero remainder modulo P. `err_o` holds until the next `sof_i` clears it.
- R7: `poly_sel_i` encoding: 0 selects the 12-bit generator x^12+x^11+x^3+x^2+x+1. 1 selects x^16+x^15+x^2+1. 2 selects x^16+x^12+x^5+1. 3 selects the 32-bit generator x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1. The register starts at zero, with no reflection and no final inversion.
- R8: `sof_i` takes effect in any state, including during check-field output. In the next cycle `fcs_valid_o` is 0 and `ready_o` is 1.
- R9: After a frame completes (check field emitted, or receive done), `ready_o` stays 0 and input bits are ignored until the next `sof_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start of frame: clear divider, latch settings |
| poly_sel_i | input | 2 | Generator select, sampled at start of frame |
| dir_i | input | 1 | 0 = send (append check field), 1 = receive (check) |
| bit_valid_i | input | 1 | Qualifies `bit_i` and `last_i` |
| bit_i | input | 1 | Serial data bit, MSB first |
| last_i | input | 1 | Marks the final bit of the data (send) or frame (receive) |
| ready_o | output | 1 | Divider accepts bits this cycle |
| fcs_valid_o | output | 1 | Check-field bit present on `fcs_bit_o` |
| fcs_bit_o | output | 1 | Check-field stream, MSB first |
| done_o | output | 1 | One-cycle strobe at end of a received frame |
| err_o | output | 1 | Nonzero remainder seen on the last received frame |

## Verification
`ready_o` goes high one cycle after the start-of-frame edge. The first check-field bit appears one cycle after the edge that takes the last data bit, and the remaining bits follow on consecutive cycles for w cycles. `done_o` and `err_o` are due one cycle after the last received bit. The bench drives inputs on falling edges and compares every output on the following falling edge, one cycle after the rising edge that produced it. It computes the expected remainder by explicit long division over a bit queue. It also compares two check fields against well-known published check values for the nine-character ASCII string "123456789".

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

  localparam int CRC_MAX_W    = 32;
  localparam int CRC_NUM_POLY = 4;
  localparam int CRC_CNT_W    = $clog2(CRC_MAX_W + 1);

  typedef enum logic [1:0] {
    POLY_C12   = 2'd0,
    POLY_C16   = 2'd1,
    POLY_CCITT = 2'd2,
    POLY_C32   = 2'd3
  } crc_poly_e;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } crc_dir_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_EMIT = 2'd2
  } crc_state_e;

  // Degree of the generator = register length = check-field length
  function automatic logic [CRC_CNT_W-1:0] crc_deg(crc_poly_e p);
    case (p)
      POLY_C12: return CRC_CNT_W'(12);
      POLY_C16: return CRC_CNT_W'(16);
      POLY_CCITT: return CRC_CNT_W'(16);
      default: return CRC_CNT_W'(32);
    endcase
  endfunction

  // Feedback taps: every nonzero term below the leading one
  function automatic logic [CRC_MAX_W-1:0] crc_taps(crc_poly_e p);
    case (p)
      POLY_C12: return CRC_MAX_W'(32'h0000_080F);
      POLY_C16: return CRC_MAX_W'(32'h0000_8005);
      POLY_CCITT: return CRC_MAX_W'(32'h0000_1021);
      default: return CRC_MAX_W'(32'h04C1_1DB7);
    endcase
  endfunction

  function automatic logic [CRC_MAX_W-1:0] crc_mask(logic [CRC_CNT_W-1:0] w);
    logic [2*CRC_MAX_W-1:0] m;
    m = ({{(2*CRC_MAX_W-1){1'b0}}, 1'b1} << w) - 1'b1;
    return m[CRC_MAX_W-1:0];
  endfunction

  function automatic logic crc_top_bit(logic [CRC_MAX_W-1:0] r, crc_poly_e p);
    logic [CRC_CNT_W-1:0] idx;
    idx = crc_deg(p) - 1'b1;
    return r[idx[$clog2(CRC_MAX_W)-1:0]];
  endfunction

  // One division step: feed one message bit into the remainder
  function automatic logic [CRC_MAX_W-1:0] crc_step(logic [CRC_MAX_W-1:0] r,
                                                     logic b, crc_poly_e p);
    logic                 fb;
    logic [CRC_MAX_W-1:0] n;
    fb = b ^ crc_top_bit(r, p);
    n  = (r << 1) & crc_mask(crc_deg(p));
    if (fb) n = n ^ crc_taps(p);
    return n;
  endfunction

  // Output shift: move the next check bit to the top, no feedback
  function automatic logic [CRC_MAX_W-1:0] crc_emit(logic [CRC_MAX_W-1:0] r,
                                                     crc_poly_e p);
    return (r << 1) & crc_mask(crc_deg(p));
  endfunction

endpackage

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
  import crc_serial_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sof_i,
  input  crc_poly_e sel_i,
  input  crc_dir_e  dir_i,
  input  logic      bit_valid_i,
  input  logic      last_i,
  output crc_poly_e sel_o,
  output logic      clr_o,
  output logic      shift_o,
  output logic      emit_o,
  output logic      rx_end_o,
  output logic      ready_o,
  output logic      fcs_valid_o
);

  crc_state_e           state_q;
  crc_poly_e            sel_q;
  crc_dir_e             dir_q;
  logic [CRC_CNT_W-1:0] cnt_q;

  assign sel_o       = sel_q;
  assign clr_o       = sof_i;
  assign ready_o     = (state_q == ST_RUN);
  assign fcs_valid_o = (state_q == ST_EMIT);
  assign shift_o     = ready_o && bit_valid_i && !sof_i;
  assign emit_o      = fcs_valid_o && !sof_i;
  assign rx_end_o    = shift_o && last_i && (dir_q == DIR_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= POLY_C12;
      dir_q   <= DIR_TX;
      cnt_q   <= '0;
    end else if (sof_i) begin
      state_q <= ST_RUN;
      sel_q   <= sel_i;
      dir_q   <= dir_i;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (shift_o && last_i) begin
            if (dir_q == DIR_TX) begin
              state_q <= ST_EMIT;
              cnt_q   <= crc_deg(sel_q) - 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_EMIT: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R4
  tx_last_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_o && last_i && dir_q == DIR_TX) |=> fcs_valid_o);

  // R5
  no_shift_in_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_valid_o |-> !shift_o);

  // R8
  sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> (ready_o && !fcs_valid_o));

endmodule

// File: rtl/crc_div_reg.sv
module crc_div_reg
  import crc_serial_pkg::*;
#(
  parameter int NUM_POLY = CRC_NUM_POLY
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr_i,
  input  logic      shift_i,
  input  logic      bit_i,
  input  logic      emit_i,
  input  crc_poly_e sel_i,
  output logic      top_o,
  output logic      nxt_zero_o
);

  localparam int W = CRC_MAX_W;

  logic [W-1:0] rem_q;
  logic [W-1:0] rem_d;
  logic [W-1:0] step_cand [NUM_POLY];

  // One divider step per generator; the latched select picks one
  for (genvar g = 0; g < NUM_POLY; g++) begin : g_poly
    assign step_cand[g] = crc_step(rem_q, bit_i, crc_poly_e'(2'(g)));
  end

  assign top_o      = crc_top_bit(rem_q, sel_i);
  assign nxt_zero_o = (step_cand[sel_i] == '0);

  always_comb begin
    rem_d = rem_q;
    if (clr_i)        rem_d = '0;
    else if (shift_i) rem_d = step_cand[sel_i];
    else if (emit_i)  rem_d = crc_emit(rem_q, sel_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  // R2
  clr_on_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (rem_q == '0));

endmodule

// File: rtl/crc_rx_judge.sv
module crc_rx_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic rx_end_i,
  input  logic nxt_zero_i,
  output logic done_o,
  output logic err_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= rx_end_i;
      if (clr_i)         err_o <= 1'b0;
      else if (rx_end_i) err_o <= !nxt_zero_i;
    end
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);

endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
  import crc_serial_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof_i,
  input  logic [1:0] poly_sel_i,
  input  logic       dir_i,
  input  logic       bit_valid_i,
  input  logic       bit_i,
  input  logic       last_i,
  output logic       ready_o,
  output logic       fcs_valid_o,
  output logic       fcs_bit_o,
  output logic       done_o,
  output logic       err_o
);

  crc_poly_e sel_w;
  logic      clr_w;
  logic      shift_w;
  logic      emit_w;
  logic      rx_end_w;
  logic      top_w;
  logic      nxt_zero_w;

  crc_frame_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof_i       (sof_i),
    .sel_i       (crc_poly_e'(poly_sel_i)),
    .dir_i       (crc_dir_e'(dir_i)),
    .bit_valid_i (bit_valid_i),
    .last_i      (last_i),
    .sel_o       (sel_w),
    .clr_o       (clr_w),
    .shift_o     (shift_w),
    .emit_o      (emit_w),
    .rx_end_o    (rx_end_w),
    .ready_o     (ready_o),
    .fcs_valid_o (fcs_valid_o)
  );

  crc_div_reg #(.NUM_POLY(CRC_NUM_POLY)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_w),
    .shift_i    (shift_w),
    .bit_i      (bit_i),
    .emit_i     (emit_w),
    .sel_i      (sel_w),
    .top_o      (top_w),
    .nxt_zero_o (nxt_zero_w)
  );

  crc_rx_judge u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_w),
    .rx_end_i   (rx_end_w),
    .nxt_zero_i (nxt_zero_w),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  assign fcs_bit_o = fcs_valid_o & top_w;

endmodule

// File: tb/crc_serial_unit_tb_top.sv
module crc_serial_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sof;
  logic [1:0] poly_sel;
  logic       dir_in;
  logic       bit_valid;
  logic       bit_in;
  logic       last;
  logic       ready_o, fcs_valid_o, fcs_bit_o, done_o, err_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  summary_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_serial_unit dut_i (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .poly_sel_i(poly_sel), .dir_i(dir_in),
    .bit_valid_i(bit_valid), .bit_i(bit_in), .last_i(last),
    .ready_o(ready_o), .fcs_valid_o(fcs_valid_o), .fcs_bit_o(fcs_bit_o),
    .done_o(done_o), .err_o(err_o)
  );

  function automatic int ref_deg(input int sel);
    case (sel)
      0: return 12;
      1, 2: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [32:0] ref_gen(input int sel);
    case (sel)
      0: return 33'h0_0000_180F;
      1: return 33'h0_0001_8005;
      2: return 33'h0_0001_1021;
      default: return 33'h1_04C1_1DB7;
    endcase
  endfunction

  // Long division over a bit queue; augment appends w zeros first
  function automatic logic [31:0] ref_rem(input int sel, input bit msg[$], input bit augment);
    int          w;
    logic [32:0] g;
    bit          a[$];
    logic [31:0] r;
    w = ref_deg(sel);
    g = ref_gen(sel);
    a = msg;
    if (augment) repeat (w) a.push_back(1'b0);
    for (int i = 0; i + w < a.size(); i++)
      if (a[i]) for (int j = 0; j <= w; j++) a[i+j] = a[i+j] ^ g[w-j];
    r = '0;
    for (int j = 0; j < w; j++) r = {r[30:0], 1'(a[a.size()-w+j])};
    return r;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input bit rdy, input bit fv,
                         input bit dn, input bit er);
    chk(req, "ready_o", 32'(ready_o), 32'(rdy));
    chk(req, "fcs_valid_o", 32'(fcs_valid_o), 32'(fv));
    chk(req, "done_o", 32'(done_o), 32'(dn));
    chk(req, "err_o", 32'(err_o), 32'(er));
  endtask

  task automatic run_frame(input bit dir, input int sel, input bit bits[$],
                           input bit gaps, input bit noise, input bit swap,
                           input string req, output logic [31:0] fcs);
    int          w;
    logic [31:0] rem;
    bit          exp_err;
    w       = ref_deg(sel);
    rem     = ref_rem(sel, bits, 1'b1);
    exp_err = (ref_rem(sel, bits, 1'b0) != 0);
    sof = 1; poly_sel = 2'(sel); dir_in = dir; bit_valid = 0; last = 0;
    step();
    sof = 0;
    chk_out("R2", 1, 0, 0, 0);
    if (swap) begin poly_sel = 2'(sel + 1); dir_in = !dir; end
    for (int i = 0; i < bits.size(); i++) begin
      if (gaps && (i % 3 == 1)) begin
        bit_valid = 0; bit_in = !bits[i]; last = 1;
        step();
        chk_out("R3", 1, 0, 0, 0);
      end
      bit_valid = 1; bit_in = bits[i]; last = (i == bits.size() - 1);
      step();
      if (i != bits.size() - 1) chk_out("R3", 1, 0, 0, 0);
    end
    bit_valid = 0; last = 0;
    fcs = '0;
    if (dir == 1'b0) begin
      for (int j = 0; j < w; j++) begin
        chk(req, "fcs_valid_o", 32'(fcs_valid_o), 32'd1);
        chk("R5", "ready_o", 32'(ready_o), 32'd0);
        chk(req, "fcs_bit_o", 32'(fcs_bit_o), 32'(rem[w-1-j]));
        fcs = {fcs[30:0], fcs_bit_o};
        if (noise) begin
          bit_valid = 1; bit_in = 1'($urandom); last = 1'($urandom);
        end
        step();
      end
      bit_valid = 0; last = 0;
      chk_out("R9", 0, 0, 0, 0);
    end else begin
      chk(req, "done_o", 32'(done_o), 32'd1);
      chk(req, "err_o", 32'(err_o), 32'(exp_err));
      chk("R5", "fcs_valid_o", 32'(fcs_valid_o), 32'd0);
      step();
      chk_out("R6", 0, 0, 0, exp_err);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

  initial begin
    bit          msg[$];
    bit          frm[$];
    logic [31:0] fcs;
    logic [31:0] dummy;
    string       s;

    rst_n = 0; sof = 0; poly_sel = 0; dir_in = 0; bit_valid = 0; bit_in = 0; last = 0;
    void'($urandom(32'd7));
    step();
    chk_out("R1", 0, 0, 0, 0);
    chk("R1", "fcs_bit_o", 32'(fcs_bit_o), 32'd0);
    step();
    rst_n = 1;
    bit_valid = 1; bit_in = 1; last = 1;
    step();
    chk_out("R1", 0, 0, 0, 0);
    bit_valid = 0; last = 0;

    // R7: published check values for ASCII "123456789"
    s = "123456789";
    msg = {};
    for (int i = 0; i < s.len(); i++)
      for (int b = 7; b >= 0; b--) msg.push_back(s[i][b]);
    run_frame(0, 2, msg, 0, 0, 0, "R4", fcs);
    chk("R7", "ccitt check value", fcs, 32'h31C3);
    run_frame(0, 1, msg, 0, 0, 0, "R4", fcs);
    chk("R7", "16-bit check value", fcs, 32'hFEE8);

    // Each generator: send, then receive good, single-error and burst-error frames
    for (int sel = 0; sel < 4; sel++) begin
      int w;
      int start;
      w = ref_deg(sel);
      msg = {};
      for (int i = 0; i < 9 + 7 * sel; i++) msg.push_back(1'($urandom));
      run_frame(0, sel, msg, 1, 1, 0, "R4", fcs);
      frm = msg;
      for (int j = w - 1; j >= 0; j--) frm.push_back(fcs[j]);
      run_frame(1, sel, frm, 1, 0, 1, "R6", dummy);
      chk("R6", "good frame err_o", 32'(err_o), 32'd0);
      frm[3] = !frm[3];
      run_frame(1, sel, frm, 0, 0, 0, "R6", dummy);
      chk("R6", "single error err_o", 32'(err_o), 32'd1);
      frm[3] = !frm[3];
      start = 2;
      frm[start] = !frm[start];
      frm[start + w - 1] = !frm[start + w - 1];
      for (int k = start + 1; k < start + w - 1; k++)
        if ($urandom % 2 == 1) frm[k] = !frm[k];
      run_frame(1, sel, frm, 0, 0, 0, "R6", dummy);
      chk("R6", "burst error err_o", 32'(err_o), 32'd1);
    end

    // R8: restart during check-field output
    msg = {};
    for (int i = 0; i < 10; i++) msg.push_back(1'($urandom));
    sof = 1; poly_sel = 2'd3; dir_in = 0;
    step();
    sof = 0;
    for (int i = 0; i < msg.size(); i++) begin
      bit_valid = 1; bit_in = msg[i]; last = (i == msg.size() - 1);
      step();
    end
    bit_valid = 0; last = 0;
    step(); step();
    chk("R4", "fcs_valid_o mid emit", 32'(fcs_valid_o), 32'd1);
    sof = 1; poly_sel = 2'd0; dir_in = 0;
    step();
    sof = 0;
    chk_out("R8", 1, 0, 0, 0);
    run_frame(0, 0, msg, 0, 0, 0, "R8", fcs);

    // R9: stray bits after a finished frame are ignored
    bit_valid = 1; last = 0;
    for (int i = 0; i < 4; i++) begin
      bit_in = 1'($urandom); last = (i == 3);
      step();
      chk_out("R9", 0, 0, 0, 0);
    end
    bit_valid = 0; last = 0;
    frm = msg;
    for (int j = 11; j >= 0; j--) frm.push_back(fcs[j]);
    run_frame(1, 0, frm, 0, 0, 0, "R9", dummy);
    chk("R9", "clean frame after stray bits", 32'(err_o), 32'd0);

    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

endmodule